// File: doc/BRIEF.md
# Camera Byte-Pair Pixel Capture Writer

This block runs on the camera's pixel clock. It takes the sensor's 8-bit parallel data bus together with a frame qualifier and a line qualifier. While both qualifiers are in their valid state, it gathers bytes in pairs. Each pair becomes one 16-bit pixel, which is written with a linear address into the write port of an external dual-port frame buffer. By default the buffer holds a 320×240 window, which is 76,800 locations. The RAM, the display read side and any colour handling lie outside the block.

A four-state machine decides when capture is allowed:

- **OFF**: the machine rests here while `enable` or `config_done` is low. Both high moves it to SKIP, or to ARM when SKIP_FRAMES is 0.
- **SKIP**: the machine counts frame ends. On the SKIP_FRAMES-th frame end it moves to ARM. This lets the sensor settle after configuration.
- **ARM**: on a frame start it clears the write address and moves to CAPTURE.
- **CAPTURE**: bytes are paired and written. On a frame end it pulses `frame_done` and returns to ARM.

From every state, a low `enable` or a low `config_done` forces a return to OFF.

Top module: `cam_pair_writer`

## Requirements
- R1: Each written pixel takes the first byte of its pair on `wr_data[15:8]` and the second byte on `wr_data[7:0]`.
- R2: A byte is taken only on a pixel-clock edge where the frame qualifier is valid (`frm_sync` low with the default polarity) and `line_vld` is high. Bytes presented at any other time produce no write.
- R3: `wr_en` is high for exactly one clock per completed pair. It rises in the cycle after the edge that takes the second byte.
- R4: The first pixel written in each captured frame goes to address 0. Each further write goes to the next address up.
- R5: The pairing phase restarts whenever `line_vld` drops. A trailing odd byte on a line is discarded and never joins a byte of the next line.
- R6: Once address DEPTH-1 (76,799 by default) has been written, no further write occurs in that frame.
- R7: After `enable` and `config_done` are both high, the first SKIP_FRAMES (default 2) complete frames produce no writes. While either input is low nothing is written. Dropping either input and raising it again restarts the discard count.
- R8: `frame_done` is a one-clock pulse. It appears in the cycle after the edge where the frame qualifier goes invalid at the end of a captured frame. It is never raised for a discarded frame.
- R9: After reset, `wr_en`, `frame_done`, `wr_addr` and `wr_data` are all zero and the machine is in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock from the sensor |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; a rise restarts frame discarding |
| config_done | input | 1 | High once sensor configuration has finished |
| frm_sync | input | 1 | Frame qualifier, valid low by default |
| line_vld | input | 1 | Line qualifier, valid high |
| din | input | 8 | Sensor data byte |
| wr_en | output | 1 | Buffer write strobe, one cycle per pixel |
| wr_addr | output | ADDR_W | Linear buffer write address |
| wr_data | output | 16 | Assembled pixel |
| frame_done | output | 1 | One-cycle pulse at the end of a captured frame |

## Verification
The bench uses a 4×3 window with two discarded frames. It drives full frames whose byte values come from the frame, line and column numbers, so a byte that is swapped, shifted or taken from the wrong line shows up in the data. Frames with even line lengths check pairing and addressing. Oversize frames separate a saturating address from one that wraps. Odd line lengths separate a phase that restarts per line from one that carries over. Stray bytes sent with only one qualifier valid, and frames sent while `config_done` or `enable` is low, show whether gating and discard counting are correct.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SKIP,
        ST_ARM,
        ST_CAPTURE
    } cap_state_t;

endpackage

// File: rtl/cam_frame_fsm.sv
module cam_frame_fsm
    import cam_cap_pkg::*;
#(
    parameter int SKIP_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic config_done,
    input  logic frame_start,
    input  logic frame_end,
    output logic capture_on,
    output logic addr_clr,
    output logic done_set
);

    localparam int SK_W = (SKIP_FRAMES > 1) ? $clog2(SKIP_FRAMES + 1) : 1;
    localparam logic [SK_W-1:0] SK_LAST = SK_W'((SKIP_FRAMES > 0) ? SKIP_FRAMES - 1 : 0);

    cap_state_t        state_q, state_d;
    logic [SK_W-1:0]   skip_q;

    // state register and discard counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            skip_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SKIP)
                skip_q <= '0;
            else if (frame_end)
                skip_q <= skip_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        capture_on = 1'b0;
        addr_clr   = 1'b0;
        done_set   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                state_d = (SKIP_FRAMES == 0) ? ST_ARM : ST_SKIP;
            end
            ST_SKIP: begin
                if (frame_end && skip_q == SK_LAST)
                    state_d = ST_ARM;
            end
            ST_ARM: begin
                if (frame_start) begin
                    addr_clr = 1'b1;
                    state_d  = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                capture_on = 1'b1;
                if (frame_end) begin
                    done_set = 1'b1;
                    state_d  = ST_ARM;
                end
            end
            default: state_d = ST_OFF;
        endcase
        if (!enable || !config_done)
            state_d = ST_OFF;
    end

endmodule

// File: rtl/cam_pair_pack.sv
module cam_pair_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] din,
    output logic              pair_vld,
    output logic [2*BYTE_W-1:0] pixel
);

    logic              phase_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            hi_q    <= '0;
        end else if (!cap_en) begin
            phase_q <= 1'b0;
        end else if (!phase_q) begin
            hi_q    <= din;
            phase_q <= 1'b1;
        end else begin
            phase_q <= 1'b0;
        end
    end

    always_comb begin
        pair_vld = cap_en & phase_q;
        pixel    = {hi_q, din};
    end

endmodule

// File: rtl/cam_addr_gen.sv
module cam_addr_gen #(
    parameter int DEPTH  = 76800,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              full
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            full <= 1'b0;
        end else if (clr) begin
            addr <= '0;
            full <= 1'b0;
        end else if (adv && !full) begin
            if (addr == LAST)
                full <= 1'b1;
            else
                addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/cam_pair_writer.sv
module cam_pair_writer #(
    parameter int H_PIX            = 320,
    parameter int V_LINES          = 240,
    parameter int SKIP_FRAMES      = 2,
    parameter bit FRAME_ACTIVE_LOW = 1'b1,
    parameter int BYTE_W           = 8,
    localparam int DEPTH           = H_PIX * V_LINES,
    localparam int ADDR_W          = $clog2(DEPTH),
    localparam int PIX_W           = 2 * BYTE_W
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              config_done,
    input  logic              frm_sync,
    input  logic              line_vld,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic              frame_done
);

    logic frm_act, frm_act_q, frame_start, frame_end;
    logic capture_on, addr_clr, done_set;
    logic cap_en, pair_vld, full, wr_go;
    logic [PIX_W-1:0]  pixel;
    logic [ADDR_W-1:0] addr;

    assign frm_act = FRAME_ACTIVE_LOW ? ~frm_sync : frm_sync;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) frm_act_q <= 1'b0;
        else        frm_act_q <= frm_act;
    end

    assign frame_start = frm_act & ~frm_act_q;
    assign frame_end   = ~frm_act & frm_act_q;

    cam_frame_fsm #(
        .SKIP_FRAMES (SKIP_FRAMES)
    ) u_fsm (
        .clk         (pclk),
        .rst_n       (rst_n),
        .enable      (enable),
        .config_done (config_done),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .capture_on  (capture_on),
        .addr_clr    (addr_clr),
        .done_set    (done_set)
    );

    assign cap_en = capture_on & frm_act & line_vld;

    cam_pair_pack #(
        .BYTE_W (BYTE_W)
    ) u_pack (
        .clk      (pclk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .din      (din),
        .pair_vld (pair_vld),
        .pixel    (pixel)
    );

    cam_addr_gen #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk   (pclk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .adv   (pair_vld),
        .addr  (addr),
        .full  (full)
    );

    assign wr_go = pair_vld & ~full;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
        end else begin
            wr_en      <= wr_go;
            frame_done <= done_set;
            if (wr_go) begin
                wr_addr <= addr;
                wr_data <= pixel;
            end
        end
    end

endmodule

// File: rtl/cam_pair_writer_chk.sv
module cam_pair_writer_chk #(
    parameter int DEPTH  = 76800,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input logic              pclk,
    input logic              rst_n,
    input logic              config_done,
    input logic              line_vld,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              frame_done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // R3
    wr_single_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2
    wr_line_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        wr_en |-> $past(line_vld));

    // R6
    no_overflow_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (wr_en && wr_addr == LAST) |=> !wr_en);

    // R7
    cfg_gate_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        !config_done |=> ##1 !wr_en);

    // R8
    done_pulse_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind cam_pair_writer cam_pair_writer_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .config_done (config_done),
    .line_vld    (line_vld),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .frame_done  (frame_done)
);

// File: tb/cam_pair_writer_bench.sv
module cam_pair_writer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HP = 4;
    localparam int VL = 3;
    localparam int NPIX = HP * VL;
    localparam int AW = $clog2(NPIX);

    logic          pclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          config_done = 1'b0;
    logic          frm_sync = 1'b1;
    logic          line_vld = 1'b0;
    logic [7:0]    din = 8'h00;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          frame_done;

    int n_cmp = 0;
    int n_bad = 0;
    int nw = 0;
    int nd = 0;
    int dbl = 0;
    bit prev_we = 1'b0;
    bit prev_fd = 1'b0;
    bit finished = 1'b0;
    logic [AW-1:0] ga [0:63];
    logic [15:0]   gd [0:63];

    always #(CLK_PERIOD / 2) pclk = ~pclk;

    cam_pair_writer #(
        .H_PIX       (HP),
        .V_LINES     (VL),
        .SKIP_FRAMES (2)
    ) u_cam_pair_writer (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .enable      (enable),
        .config_done (config_done),
        .frm_sync    (frm_sync),
        .line_vld    (line_vld),
        .din         (din),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_done  (frame_done)
    );

    // output monitor, away from the active edge
    always @(negedge pclk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (nw < 64) begin
                    ga[nw] = wr_addr;
                    gd[nw] = wr_data;
                end
                nw++;
                if (prev_we) dbl++;
            end
            if (frame_done) begin
                nd++;
                if (prev_fd) dbl++;
            end
            prev_we = wr_en;
            prev_fd = frame_done;
        end
    end

    function automatic logic [7:0] bval(input int f, input int l, input int i);
        return 8'((f * 37 + l * 16 + i * 3 + 1) % 256);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nw = 0;
        nd = 0;
        dbl = 0;
    endtask

    task automatic run_frame(input int f, input int nl, input int nb);
        // stray bytes with line valid but frame invalid (R2)
        @(negedge pclk);
        frm_sync = 1'b1;
        line_vld = 1'b1;
        for (int i = 0; i < 3; i++) begin
            din = 8'h5A + 8'(i);
            @(negedge pclk);
        end
        line_vld = 1'b0;
        repeat (2) @(negedge pclk);
        frm_sync = 1'b0;
        repeat (2) @(negedge pclk);
        for (int l = 0; l < nl; l++) begin
            line_vld = 1'b1;
            for (int i = 0; i < nb; i++) begin
                din = bval(f, l, i);
                @(negedge pclk);
            end
            line_vld = 1'b0;
            din = 8'hAA;
            repeat (2) @(negedge pclk);
        end
        frm_sync = 1'b1;
        repeat (4) @(negedge pclk);
    endtask

    task automatic check_frame(input string tag, input int f, input int nl,
                               input int nb, input bit cap);
        int ppl = nb / 2;
        int total = cap ? ((nl * ppl < NPIX) ? nl * ppl : NPIX) : 0;
        check({tag, " R2 R6 R7 write count"}, nw, total);
        check({tag, " R8 frame_done count"}, nd, cap ? 1 : 0);
        check({tag, " R3 R8 single-cycle strobes"}, dbl, 0);
        for (int k = 0; k < total && k < 64; k++) begin
            int ln = k / ppl;
            int p = k % ppl;
            check({tag, " R4 address"}, int'(ga[k]), k);
            check({tag, " R1 R5 pixel"}, int'(gd[k]),
                  int'({bval(f, ln, 2 * p), bval(f, ln, 2 * p + 1)}));
        end
    endtask

    task automatic frame_case(input string tag, input int f, input int nl,
                              input int nb, input bit cap);
        clear_mon();
        run_frame(f, nl, nb);
        check_frame(tag, f, nl, nb, cap);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        // R9 reset state
        check("R9 wr_en", int'(wr_en), 0);
        check("R9 frame_done", int'(frame_done), 0);
        check("R9 wr_addr", int'(wr_addr), 0);
        check("R9 wr_data", int'(wr_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge pclk);
        enable = 1'b1;
        config_done = 1'b1;
        @(negedge pclk);

        frame_case("skip0 R7", 0, 3, 8, 1'b0);
        frame_case("skip1 R7", 1, 3, 8, 1'b0);
        frame_case("normal", 2, 3, 8, 1'b1);
        frame_case("oversize R6", 3, 4, 8, 1'b1);
        frame_case("oddline R5", 4, 3, 7, 1'b1);
        frame_case("short R4", 5, 2, 4, 1'b1);

        config_done = 1'b0;
        frame_case("cfglow R7", 6, 3, 8, 1'b0);
        config_done = 1'b1;
        frame_case("reskipA R7", 7, 3, 8, 1'b0);
        frame_case("reskipB R7", 8, 3, 8, 1'b0);
        frame_case("aftercfg", 9, 3, 8, 1'b1);

        enable = 1'b0;
        frame_case("enlow R7", 10, 3, 8, 1'b0);
        enable = 1'b1;
        frame_case("reskipC R7", 11, 2, 6, 1'b0);
        frame_case("reskipD R7", 12, 2, 6, 1'b0);
        frame_case("afteren", 13, 3, 6, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge pclk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule